// File: doc/BRIEF.md
# Prioritized Local Interrupt Acceptance Controller

This block sits beside one processor core and decides which incoming interrupt messages it takes, which it refuses, and which one the core should service next. Every message carries an 8-bit vector, a 3-bit delivery type and a trigger mode (edge or level). Fixed-type messages are kept in a 256-bit pending register, one slot per vector. Special types (NMI, SMI, INIT, external, startup) skip the queues and are passed straight to the core.

The block offers the core the best pending vector. A vector's class is its upper nibble. The offer is made only when that class is strictly above the processor priority. The processor priority is the larger of the task-priority class and the class of the highest in-service vector. On acknowledge, the vector moves from pending to in-service. A later end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, the block then emits a broadcast carrying the vector.

Top module: `irq_accept_ctrl`

## Requirements
- R1: The class of a vector is bits 7:4. `core_req` is high exactly when some vector is pending and its class is strictly greater than max(task-priority bits 7:4, class of the highest in-service vector, or 0 if none). A task-priority write takes effect from the next cycle.
- R2: `core_vector` carries the highest-numbered pending vector. Within a class, the higher number wins.
- R3: A fixed message (type 0) with vector 16..255 and its pending bit clear gets `msg_accept` in the same cycle, and its pending bit is set from the next cycle. If the pending bit is already set, the message gets `msg_retry` instead. Accept and retry are never high together.
- R4: Types 1 (SMI), 2 (NMI), 3 (INIT), 4 (external) and 5 (startup) get `msg_accept` in the same cycle. They appear on `fwd_valid`/`fwd_dtype`/`fwd_vector` in that cycle and change no pending state.
- R5: A fixed message with vector below 16 gets neither accept nor retry. It sets `err_illegal` from the next cycle, and only reset clears that flag.
- R6: `core_ack` while `core_req` is high clears the offered vector's pending bit, sets its in-service bit and records its trigger mode. A fresh message for that vector is then accepted.
- R7: `eoi_we` clears the highest in-service bit. If that vector was accepted as level-triggered, `eoi_bcast_valid` pulses for one cycle on the next cycle with `eoi_bcast_vector` equal to it.
- R8: `eoi_we` with no in-service bit set changes nothing and raises no broadcast. An EOI that retires an edge-triggered vector raises no broadcast either.
- R9: Types 6 and 7 are reserved and always get `msg_retry`.
- R10: After reset nothing is pending or in service, task priority is 0, `core_req`, `eoi_bcast_valid` and `err_illegal` are 0.
- R11: `core_ack` while `core_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming interrupt message present |
| msg_vector | input | 8 | Message vector |
| msg_dtype | input | 3 | Delivery type (0 fixed, 1..5 special, 6..7 reserved) |
| msg_level | input | 1 | Trigger mode: 1 level, 0 edge |
| msg_accept | output | 1 | Message taken this cycle |
| msg_retry | output | 1 | Message refused, sender must retry |
| fwd_valid | output | 1 | Special message forwarded to core |
| fwd_dtype | output | 3 | Forwarded delivery type |
| fwd_vector | output | 8 | Forwarded vector |
| core_req | output | 1 | Interrupt offered to the core |
| core_vector | output | 8 | Offered vector |
| core_ack | input | 1 | Core takes the offered vector |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority value |
| eoi_we | input | 1 | End-of-interrupt strobe |
| eoi_bcast_valid | output | 1 | End-of-interrupt broadcast for a level vector |
| eoi_bcast_vector | output | 8 | Vector being broadcast |
| err_illegal | output | 1 | Sticky illegal-vector flag |

## Verification
Acknowledge and end-of-interrupt can land in the same cycle. The EOI must then retire the old top in-service vector, while the acknowledge installs a newer, higher one. A message for the vector being acknowledged can also arrive in that same cycle, and it must be retried because its pending bit is still set when it is judged. The bench forces each of these combinations directly. Its random phase also drives acknowledge, EOI, messages and task-priority writes together at high rates. A behavioural model, using plain bit arrays and integer arithmetic, judges the outputs on every cycle.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    DT_FIXED   = 3'd0,
    DT_SMI     = 3'd1,
    DT_NMI     = 3'd2,
    DT_INIT    = 3'd3,
    DT_EXTINT  = 3'd4,
    DT_STARTUP = 3'd5,
    DT_RSV6    = 3'd6,
    DT_RSV7    = 3'd7
  } dtype_e;

  function automatic logic is_special(dtype_e t);
    return (t == DT_SMI) || (t == DT_NMI) || (t == DT_INIT) ||
           (t == DT_EXTINT) || (t == DT_STARTUP);
  endfunction

  function automatic logic is_reserved(dtype_e t);
    return (t == DT_RSV6) || (t == DT_RSV7);
  endfunction

endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_pend,
  input  logic [W-1:0] set_idx,
  input  logic         set_lvl,
  input  logic         ack,
  input  logic [W-1:0] ack_idx,
  input  logic         retire,
  input  logic [W-1:0] retire_idx,
  output logic [N-1:0] irr,
  output logic [N-1:0] isr,
  output logic [N-1:0] tmr
);
  logic [N-1:0] plvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr  <= '0;
      isr  <= '0;
      tmr  <= '0;
      plvl <= '0;
    end else begin
      if (set_pend) begin
        irr[set_idx]  <= 1'b1;
        plvl[set_idx] <= set_lvl;
      end
      if (ack) begin
        irr[ack_idx] <= 1'b0;
        isr[ack_idx] <= 1'b1;
        tmr[ack_idx] <= plvl[ack_idx];
      end
      if (retire) begin
        isr[retire_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLS_W   = 4,
  parameter int MIN_VEC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [VEC_W-1:0] msg_vector,
  input  logic [2:0]       msg_dtype,
  input  logic             msg_level,
  output logic             msg_accept,
  output logic             msg_retry,
  output logic             fwd_valid,
  output logic [2:0]       fwd_dtype,
  output logic [VEC_W-1:0] fwd_vector,
  output logic             core_req,
  output logic [VEC_W-1:0] core_vector,
  input  logic             core_ack,
  input  logic             tpr_we,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             eoi_we,
  output logic             eoi_bcast_valid,
  output logic [VEC_W-1:0] eoi_bcast_vector,
  output logic             err_illegal
);
  localparam int NVEC = 1 << VEC_W;

  function automatic logic [CLS_W-1:0] cls_of(logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  function automatic logic [CLS_W-1:0] cls_max(logic [CLS_W-1:0] a,
                                               logic [CLS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  dtype_e             dt;
  logic [NVEC-1:0]    irr_q, isr_q, tmr_q;
  logic               pend_any, svc_any;
  logic [VEC_W-1:0]   pend_top, svc_top;
  logic [VEC_W-1:0]   tpr_q;
  logic [CLS_W-1:0]   ppr_cls;
  logic               fixed_ok, take_fixed, illegal_hit, ack_fire, eoi_fire;

  assign dt          = dtype_e'(msg_dtype);
  assign fixed_ok    = msg_valid && (dt == DT_FIXED) && (msg_vector >= VEC_W'(MIN_VEC));
  assign illegal_hit = msg_valid && (dt == DT_FIXED) && (msg_vector <  VEC_W'(MIN_VEC));
  assign take_fixed  = fixed_ok && !irr_q[msg_vector];

  assign msg_accept = take_fixed || (msg_valid && is_special(dt));
  assign msg_retry  = (fixed_ok && irr_q[msg_vector]) || (msg_valid && is_reserved(dt));

  assign fwd_valid  = msg_valid && is_special(dt);
  assign fwd_dtype  = msg_dtype;
  assign fwd_vector = msg_vector;

  irq_hi_find #(.N(NVEC), .W(VEC_W)) u_pend_find (
    .bits(irr_q), .any(pend_any), .idx(pend_top)
  );
  irq_hi_find #(.N(NVEC), .W(VEC_W)) u_svc_find (
    .bits(isr_q), .any(svc_any), .idx(svc_top)
  );

  assign ppr_cls     = cls_max(cls_of(tpr_q), svc_any ? cls_of(svc_top) : '0);
  assign core_req    = pend_any && (cls_of(pend_top) > ppr_cls);
  assign core_vector = pend_top;
  assign ack_fire    = core_ack && core_req;
  assign eoi_fire    = eoi_we && svc_any;

  irq_vec_regs #(.N(NVEC), .W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .set_pend(take_fixed), .set_idx(msg_vector), .set_lvl(msg_level),
    .ack(ack_fire), .ack_idx(pend_top),
    .retire(eoi_fire), .retire_idx(svc_top),
    .irr(irr_q), .isr(isr_q), .tmr(tmr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q            <= '0;
      err_illegal      <= 1'b0;
      eoi_bcast_valid  <= 1'b0;
      eoi_bcast_vector <= '0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata;
      if (illegal_hit) err_illegal <= 1'b1;
      eoi_bcast_valid  <= eoi_fire && tmr_q[svc_top];
      eoi_bcast_vector <= svc_top;
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic [VEC_W-1:0]     msg_vector,
  input logic [2:0]           msg_dtype,
  input logic                 msg_accept,
  input logic                 msg_retry,
  input logic                 core_req,
  input logic [VEC_W-1:0]     core_vector,
  input logic                 core_ack,
  input logic                 eoi_we,
  input logic                 eoi_bcast_valid,
  input logic                 err_illegal,
  input logic [(1<<VEC_W)-1:0] irr_q,
  input logic [(1<<VEC_W)-1:0] isr_q,
  input logic [VEC_W-1:0]     tpr_q
);
  assert_req_above_tpr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (core_vector[VEC_W-1 -: CLS_W] > tpr_q[VEC_W-1 -: CLS_W]));

  assert_req_is_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> irr_q[core_vector]);

  assert_accept_retry_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_accept && msg_retry));

  assert_accept_sets_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_accept && msg_dtype == 3'd0) |=> irr_q[$past(msg_vector)]);

  assert_special_no_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_dtype >= 3'd1 && msg_dtype <= 3'd5 && !core_ack)
      |=> irr_q == $past(irr_q));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |=> err_illegal);

  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && core_req) |=> (isr_q[$past(core_vector)] && !irr_q[$past(core_vector)]));

  assert_bcast_after_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(eoi_we));

  assert_empty_eoi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && isr_q == '0) |=> !eoi_bcast_valid);
endmodule

bind irq_accept_ctrl irq_accept_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
  .msg_dtype(msg_dtype), .msg_accept(msg_accept), .msg_retry(msg_retry),
  .core_req(core_req), .core_vector(core_vector), .core_ack(core_ack),
  .eoi_we(eoi_we), .eoi_bcast_valid(eoi_bcast_valid), .err_illegal(err_illegal),
  .irr_q(irr_q), .isr_q(isr_q), .tpr_q(tpr_q)
);

// File: tb/test_irq_accept_ctrl.sv
module test_irq_accept_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 0, msg_level = 0, core_ack = 0, tpr_we = 0, eoi_we = 0;
  logic [7:0] msg_vector = 0, tpr_wdata = 0;
  logic [2:0] msg_dtype = 0;
  logic msg_accept, msg_retry, fwd_valid, core_req, eoi_bcast_valid, err_illegal;
  logic [2:0] fwd_dtype;
  logic [7:0] fwd_vector, core_vector, eoi_bcast_vector;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_ctrl i_irq_accept_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_dtype(msg_dtype), .msg_level(msg_level), .msg_accept(msg_accept),
    .msg_retry(msg_retry), .fwd_valid(fwd_valid), .fwd_dtype(fwd_dtype),
    .fwd_vector(fwd_vector), .core_req(core_req), .core_vector(core_vector),
    .core_ack(core_ack), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .eoi_we(eoi_we),
    .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vector(eoi_bcast_vector),
    .err_illegal(err_illegal)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit m_irr[256], m_isr[256], m_tmr[256], m_plvl[256];
  int m_tpr = 0;
  bit m_err = 0, m_bv = 0;
  int m_bvec = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int top_irr();
    for (int i = 255; i >= 0; i--) if (m_irr[i]) return i;
    return -1;
  endfunction

  function automatic int top_isr();
    for (int i = 255; i >= 0; i--) if (m_isr[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_req();
    int pt = top_irr();
    int st = top_isr();
    int ppr = m_tpr / 16;
    if (st >= 0 && st / 16 > ppr) ppr = st / 16;
    return (pt >= 0) && (pt / 16 > ppr);
  endfunction

  // one clock: compare everything, advance model, clear inputs
  task automatic tick();
    int v, t, pt, st;
    bit eacc, eret, req, nbv;
    #1;
    v = msg_vector; t = msg_dtype;
    pt = top_irr(); st = top_isr(); req = exp_req();
    eacc = msg_valid && ((t >= 1 && t <= 5) || (t == 0 && v >= 16 && !m_irr[v]));
    eret = msg_valid && (t >= 6 || (t == 0 && v >= 16 && m_irr[v]));
    begin
      string mt;
      mt = (t >= 1 && t <= 5) ? "R4" : (t >= 6) ? "R9" : (v < 16) ? "R5" : "R3";
      check({mt, " msg_accept"}, msg_accept, eacc);
      check({mt, " msg_retry"}, msg_retry, eret);
    end
    check("R4 fwd_valid", fwd_valid, msg_valid && t >= 1 && t <= 5);
    if (fwd_valid) begin
      check("R4 fwd_dtype", fwd_dtype, t);
      check("R4 fwd_vector", fwd_vector, v);
    end
    check("R1 core_req", core_req, req);
    if (req) check("R2 core_vector", core_vector, pt);
    check("R5 err_illegal", err_illegal, m_err);
    check("R7 eoi_bcast_valid", eoi_bcast_valid, m_bv);
    if (m_bv) check("R7 eoi_bcast_vector", eoi_bcast_vector, m_bvec);
    @(posedge clk);
    nbv = eoi_we && st >= 0 && m_tmr[st > 0 ? st : 0];
    if (eoi_we && st >= 0) m_isr[st] = 0;
    if (core_ack && req) begin
      m_irr[pt] = 0; m_isr[pt] = 1; m_tmr[pt] = m_plvl[pt];
    end
    if (eacc && t == 0) begin m_irr[v] = 1; m_plvl[v] = msg_level; end
    if (msg_valid && t == 0 && v < 16) m_err = 1;
    if (tpr_we) m_tpr = tpr_wdata;
    m_bv = nbv; m_bvec = st;
    @(negedge clk);
    msg_valid = 0; core_ack = 0; tpr_we = 0; eoi_we = 0; msg_level = 0;
  endtask

  task automatic send(int vec, int typ, bit lvl);
    msg_valid = 1; msg_vector = 8'(vec); msg_dtype = 3'(typ); msg_level = lvl;
  endtask

  task automatic set_tpr(int val);
    tpr_we = 1; tpr_wdata = 8'(val);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R10 reset core_req", core_req, 0);
    check("R10 reset err_illegal", err_illegal, 0);
    check("R10 reset eoi_bcast_valid", eoi_bcast_valid, 0);
    check("R10 reset msg_accept", msg_accept, 0);
    @(negedge clk);

    // R3 basic acceptance then retry on duplicate
    send(8'h45, 0, 0); tick();
    tick();
    check("R3 offered after accept", core_vector, 8'h45);
    send(8'h45, 0, 1); tick();
    // R2 within one class higher vector wins
    send(8'h47, 0, 1); tick();
    send(8'h31, 0, 0); tick();
    tick();
    check("R2 top of class 4", core_vector, 8'h47);
    // R1 task priority gating, strict comparison
    set_tpr(8'h50); tick(); tick();
    check("R1 tpr above class", core_req, 0);
    set_tpr(8'h4F); tick(); tick();
    check("R1 tpr equal class", core_req, 0);
    // R11 ack without request has no effect
    core_ack = 1; tick();
    set_tpr(8'h30); tick(); tick();
    check("R11 still offered", core_vector, 8'h47);
    // R6 ack moves 0x47 to service; 0x45 now blocked by in-service class
    core_ack = 1; tick(); tick();
    check("R6 same class blocked", core_req, 0);
    send(8'h47, 0, 0); tick();
    tick();
    // R7 EOI of level vector 0x47 -> broadcast next cycle
    eoi_we = 1; tick();
    check("R7 broadcast pulse", eoi_bcast_valid, 1);
    check("R7 broadcast vector", eoi_bcast_vector, 8'h47);
    tick();
    // R4 special types
    send(8'h02, 2, 0); tick();
    send(8'h99, 5, 0); tick();
    // R9 reserved types
    send(8'h60, 6, 0); tick();
    send(8'h60, 7, 0); tick();
    // R5 illegal vector
    send(8'h05, 0, 0); tick();
    tick();
    check("R5 sticky flag", err_illegal, 1);
    // drain: ack 0x47 (edge now), EOI same cycle as ack of next
    core_ack = 1; tick();
    send(8'hA0, 0, 1); tick();
    // collision: ack 0xA0, EOI retires 0x47, message for 0xA0 retried
    core_ack = 1; eoi_we = 1; send(8'hA0, 0, 0); tick();
    check("R8 edge EOI no broadcast", eoi_bcast_valid, 0);
    eoi_we = 1; tick();
    check("R7 level A0 broadcast", eoi_bcast_vector, 8'hA0);
    // drain remaining in service, then empty EOI
    repeat (6) begin core_ack = 1; tick(); eoi_we = 1; tick(); end
    eoi_we = 1; tick();
    eoi_we = 1; tick();
    check("R8 empty EOI quiet", eoi_bcast_valid, 0);

    // random phase, model compared every clock
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 1) == 1) begin
        int typ = (r < 80) ? 0 : $urandom_range(1, 7);
        int vec = (r < 5) ? $urandom_range(0, 15) : $urandom_range(16, 255);
        if (r >= 40 && r < 60) vec = 16 * $urandom_range(2, 15) + $urandom_range(0, 3);
        send(vec, typ, 1'($urandom_range(0, 1)));
      end
      core_ack = ($urandom_range(0, 99) < 35);
      eoi_we   = ($urandom_range(0, 99) < 20);
      if ($urandom_range(0, 99) < 4) set_tpr($urandom_range(0, 255));
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule